// File: doc/BRIEF.md
# Descriptor Chain Manager

This block sits beside a packet receive or transmit datapath and owns the bookkeeping of a singly linked list of eight-word buffer descriptors kept in a small word-addressed memory. A control block at a fixed base address holds the short pointer to the current descriptor, the interrupt wakeup mask and a missed-packet counter. When the datapath asks for a buffer, the block follows the current pointer, reads the buffer length and the two-word buffer address, and presents them until the datapath reports that the packet is finished.

On completion the block writes the completion word, and on receive also the number of words used, back into the descriptor. It then replaces the control block's current pointer with the descriptor's link word in a single memory write, so software never sees a half-updated pointer, reads the wakeup mask and raises a one-cycle interrupt request carrying that mask. If the current pointer is zero the list is empty: the datapath is told to drop the packet, and in receive mode the missed-packet counter is bumped.

All memory traffic goes through one synchronous single-port interface, at most one access per cycle, with read data returned on the cycle after the request. The sequencing is a single state machine. Its states are: Idle, GetCur (capture the current pointer), GetLen, GetPlo, GetPhi (capture descriptor fields), Ready (buffer offered), WrUsed, WrCmpl (write-back), RdLink, WrLink (chain), RdMask, Irq, MissInc (receive with empty list) and Empty (transmit with empty list). Transitions: Idle→GetCur on start; GetCur→GetLen on a non-zero pointer, →MissInc (receive) or →Empty (transmit) on zero; GetLen→GetPlo→GetPhi→Ready; Ready→WrUsed (receive) or →WrCmpl (transmit) on done; WrUsed→WrCmpl→RdLink→WrLink→RdMask→Irq→Idle; MissInc→Idle; Empty→Idle.

Top module: `desc_chain_mgr`

## Requirements
- R1: Out of reset busy_o, mem_req_o, desc_valid_o, none_o and irq_o are all low.
- R2: After a start pulse with a non-zero pointer in control-block word 1, desc_valid_o rises within 5 cycles with buf_len_o equal to descriptor word 5 and buf_ptr_o equal to {descriptor word 7, descriptor word 6}.
- R3: If control-block word 1 is zero, none_o pulses for one cycle, desc_valid_o stays low and no interrupt is raised; in receive mode (rx_mode_i high at start) control-block word 5 is incremented by one modulo 2^DW, in transmit mode it is left unchanged.
- R4: On done_i while desc_valid_o is high, cmpl_i is written to descriptor word 3.
- R5: In receive mode used_i is written to descriptor word 4; in transmit mode descriptor word 4 is not written.
- R6: Chaining writes descriptor word 0 into control-block word 1 with exactly one write to that word per completed descriptor.
- R7: Exactly one single-cycle irq_o pulse follows each completed descriptor, two cycles after the control-block word 1 write, with irq_mask_o equal to control-block word 4.
- R8: start_i is ignored while busy_o is high, and done_i is ignored while desc_valid_o is low.
- R9: busy_o is high from the cycle after an accepted start until the transaction returns to Idle; while desc_valid_o is high and done_i is low, buf_ptr_o and buf_len_o hold.
- R10: While Idle and without a start, no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a buffer for the next packet |
| rx_mode_i | input | 1 | Sampled at start: 1 receive, 0 transmit |
| done_i | input | 1 | Datapath has finished with the offered buffer |
| cmpl_i | input | DW | Completion word to store |
| used_i | input | DW | Words used (receive only) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one cycle after a read request |
| desc_valid_o | output | 1 | Buffer fields are valid |
| buf_ptr_o | output | 2*DW | Buffer address {high, low} |
| buf_len_o | output | DW | Buffer length |
| none_o | output | 1 | Pulse: list empty, drop the packet |
| irq_o | output | 1 | Pulse: descriptor completed |
| irq_mask_o | output | DW | Wakeup mask, valid with irq_o |
| busy_o | output | 1 | Transaction in progress |

## Verification
A wrong state or a mis-captured field in this block surfaces at the ports within a handful of cycles: a bad pointer or offset shows as wrong buf_len_o/buf_ptr_o values at desc_valid_o, or as write-backs landing on the wrong words of the bench memory right after done_i. A broken chaining step leaves control-block word 1 wrong or written twice, and a mis-ordered tail moves the irq_o pulse away from its fixed two-cycle distance to that write. Sweeping chain lengths zero to four in both directions drives every state, including the empty-list paths and counter wrap.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GET_CUR,
        S_GET_LEN,
        S_GET_PLO,
        S_GET_PHI,
        S_READY,
        S_WR_USED,
        S_WR_CMPL,
        S_RD_LINK,
        S_WR_LINK,
        S_RD_MASK,
        S_IRQ,
        S_MISS_INC,
        S_EMPTY
    } dcm_state_e;

    // descriptor word offsets
    localparam int unsigned D_LINK = 0;
    localparam int unsigned D_CMPL = 3;
    localparam int unsigned D_USED = 4;
    localparam int unsigned D_LEN  = 5;
    localparam int unsigned D_PLO  = 6;
    localparam int unsigned D_PHI  = 7;

    // control block word offsets
    localparam int unsigned C_CUR  = 1;
    localparam int unsigned C_MASK = 4;
    localparam int unsigned C_MISS = 5;

endpackage

// File: rtl/dcm_fsm.sv
module dcm_fsm
    import dcm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       done_i,
    input  logic       rx_q_i,
    input  logic       ptr_zero_i,
    output dcm_state_e state_o
);

    dcm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_i) state_d = S_GET_CUR;
            S_GET_CUR: begin
                if (!ptr_zero_i)  state_d = S_GET_LEN;
                else if (rx_q_i)  state_d = S_MISS_INC;
                else              state_d = S_EMPTY;
            end
            S_GET_LEN:  state_d = S_GET_PLO;
            S_GET_PLO:  state_d = S_GET_PHI;
            S_GET_PHI:  state_d = S_READY;
            S_READY:    if (done_i) state_d = rx_q_i ? S_WR_USED : S_WR_CMPL;
            S_WR_USED:  state_d = S_WR_CMPL;
            S_WR_CMPL:  state_d = S_RD_LINK;
            S_RD_LINK:  state_d = S_WR_LINK;
            S_WR_LINK:  state_d = S_RD_MASK;
            S_RD_MASK:  state_d = S_IRQ;
            S_IRQ:      state_d = S_IDLE;
            S_MISS_INC: state_d = S_IDLE;
            S_EMPTY:    state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/dcm_desc_regs.sv
module dcm_desc_regs
    import dcm_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dcm_state_e    state_i,
    input  logic          start_i,
    input  logic          rx_mode_i,
    input  logic          done_i,
    input  logic [DW-1:0] cmpl_i,
    input  logic [DW-1:0] used_i,
    input  logic [DW-1:0] rdata_i,
    output logic          rx_q_o,
    output logic [AW-1:0] cur_q_o,
    output logic [DW-1:0] len_q_o,
    output logic [DW-1:0] plo_q_o,
    output logic [DW-1:0] phi_q_o,
    output logic [DW-1:0] cmpl_q_o,
    output logic [DW-1:0] used_q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q_o   <= 1'b0;
            cur_q_o  <= '0;
            len_q_o  <= '0;
            plo_q_o  <= '0;
            phi_q_o  <= '0;
            cmpl_q_o <= '0;
            used_q_o <= '0;
        end else begin
            unique case (state_i)
                S_IDLE:    if (start_i) rx_q_o <= rx_mode_i;
                S_GET_CUR: cur_q_o <= rdata_i[AW-1:0];
                S_GET_LEN: len_q_o <= rdata_i;
                S_GET_PLO: plo_q_o <= rdata_i;
                S_GET_PHI: phi_q_o <= rdata_i;
                S_READY: begin
                    if (done_i) begin
                        cmpl_q_o <= cmpl_i;
                        used_q_o <= used_i;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dcm_memif.sv
module dcm_memif
    import dcm_pkg::*;
#(
    parameter int          AW      = 8,
    parameter int          DW      = 16,
    parameter logic [AW-1:0] CB_BASE = '0
) (
    input  dcm_state_e    state_i,
    input  logic          start_i,
    input  logic          rx_q_i,
    input  logic [AW-1:0] cur_q_i,
    input  logic [DW-1:0] cmpl_q_i,
    input  logic [DW-1:0] used_q_i,
    input  logic [DW-1:0] rdata_i,
    output logic          req_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o
);

    localparam logic [AW-1:0] CB_CUR_A  = CB_BASE + AW'(C_CUR);
    localparam logic [AW-1:0] CB_MASK_A = CB_BASE + AW'(C_MASK);
    localparam logic [AW-1:0] CB_MISS_A = CB_BASE + AW'(C_MISS);

    logic [AW-1:0] new_ptr;
    assign new_ptr = rdata_i[AW-1:0];

    always_comb begin
        req_o   = 1'b0;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            S_IDLE: begin
                if (start_i) begin
                    req_o  = 1'b1;
                    addr_o = CB_CUR_A;
                end
            end
            S_GET_CUR: begin
                if (rdata_i != '0) begin
                    req_o  = 1'b1;
                    addr_o = new_ptr + AW'(D_LEN);
                end else if (rx_q_i) begin
                    req_o  = 1'b1;
                    addr_o = CB_MISS_A;
                end
            end
            S_GET_LEN: begin
                req_o  = 1'b1;
                addr_o = cur_q_i + AW'(D_PLO);
            end
            S_GET_PLO: begin
                req_o  = 1'b1;
                addr_o = cur_q_i + AW'(D_PHI);
            end
            S_WR_USED: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = cur_q_i + AW'(D_USED);
                wdata_o = used_q_i;
            end
            S_WR_CMPL: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = cur_q_i + AW'(D_CMPL);
                wdata_o = cmpl_q_i;
            end
            S_RD_LINK: begin
                req_o  = 1'b1;
                addr_o = cur_q_i + AW'(D_LINK);
            end
            S_WR_LINK: begin
                // link word goes straight from read data into the control block
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = CB_CUR_A;
                wdata_o = rdata_i;
            end
            S_RD_MASK: begin
                req_o  = 1'b1;
                addr_o = CB_MASK_A;
            end
            S_MISS_INC: begin
                req_o   = 1'b1;
                we_o    = 1'b1;
                addr_o  = CB_MISS_A;
                wdata_o = rdata_i + DW'(1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/desc_chain_mgr.sv
module desc_chain_mgr
    import dcm_pkg::*;
#(
    parameter int            AW      = 8,
    parameter int            DW      = 16,
    parameter logic [AW-1:0] CB_BASE = 8'hF0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            rx_mode_i,
    input  logic            done_i,
    input  logic [DW-1:0]   cmpl_i,
    input  logic [DW-1:0]   used_i,
    output logic            mem_req_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    input  logic [DW-1:0]   mem_rdata_i,
    output logic            desc_valid_o,
    output logic [2*DW-1:0] buf_ptr_o,
    output logic [DW-1:0]   buf_len_o,
    output logic            none_o,
    output logic            irq_o,
    output logic [DW-1:0]   irq_mask_o,
    output logic            busy_o
);

    dcm_state_e    state;
    logic          rx_q;
    logic [AW-1:0] cur_q;
    logic [DW-1:0] len_q, plo_q, phi_q, cmpl_q, used_q;
    logic          ptr_zero;

    assign ptr_zero = (mem_rdata_i == '0);

    dcm_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .done_i     (done_i),
        .rx_q_i     (rx_q),
        .ptr_zero_i (ptr_zero),
        .state_o    (state)
    );

    dcm_desc_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_i   (state),
        .start_i   (start_i),
        .rx_mode_i (rx_mode_i),
        .done_i    (done_i),
        .cmpl_i    (cmpl_i),
        .used_i    (used_i),
        .rdata_i   (mem_rdata_i),
        .rx_q_o    (rx_q),
        .cur_q_o   (cur_q),
        .len_q_o   (len_q),
        .plo_q_o   (plo_q),
        .phi_q_o   (phi_q),
        .cmpl_q_o  (cmpl_q),
        .used_q_o  (used_q)
    );

    dcm_memif #(.AW(AW), .DW(DW), .CB_BASE(CB_BASE)) u_memif (
        .state_i  (state),
        .start_i  (start_i),
        .rx_q_i   (rx_q),
        .cur_q_i  (cur_q),
        .cmpl_q_i (cmpl_q),
        .used_q_i (used_q),
        .rdata_i  (mem_rdata_i),
        .req_o    (mem_req_o),
        .we_o     (mem_we_o),
        .addr_o   (mem_addr_o),
        .wdata_o  (mem_wdata_o)
    );

    always_comb begin
        desc_valid_o = (state == S_READY);
        none_o       = (state == S_MISS_INC) || (state == S_EMPTY);
        irq_o        = (state == S_IRQ);
        irq_mask_o   = (state == S_IRQ) ? mem_rdata_i : '0;
        busy_o       = (state != S_IDLE);
        buf_ptr_o    = {phi_q, plo_q};
        buf_len_o    = len_q;
    end

endmodule

// File: rtl/desc_chain_mgr_chk.sv
module desc_chain_mgr_chk #(
    parameter int            AW      = 8,
    parameter int            DW      = 16,
    parameter logic [AW-1:0] CB_BASE = 8'hF0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            done_i,
    input logic            mem_req_o,
    input logic            mem_we_o,
    input logic [AW-1:0]   mem_addr_o,
    input logic            desc_valid_o,
    input logic [2*DW-1:0] buf_ptr_o,
    input logic [DW-1:0]   buf_len_o,
    input logic            none_o,
    input logic            irq_o,
    input logic            busy_o
);

    localparam logic [AW-1:0] CUR_A = CB_BASE + AW'(1);

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_after_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(mem_we_o && mem_addr_o == CUR_A, 2));

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_offer_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid_o && !done_i) |=> desc_valid_o && $stable(buf_ptr_o) && $stable(buf_len_o));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |-> !mem_req_o);

    p_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !busy_o && !start_i) |=> !busy_o);

    p_none_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        none_o |=> !busy_o && !irq_o);

endmodule

bind desc_chain_mgr desc_chain_mgr_chk #(.AW(AW), .DW(DW), .CB_BASE(CB_BASE)) u_chk (.*);

// File: tb/desc_chain_mgr_tb.sv
module desc_chain_mgr_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam logic [AW-1:0] CB = 8'hF0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0, rx_mode_i = 1'b0, done_i = 1'b0;
    logic [DW-1:0]   cmpl_i = '0, used_i = '0;
    logic            mem_req_o, mem_we_o;
    logic [AW-1:0]   mem_addr_o;
    logic [DW-1:0]   mem_wdata_o;
    logic [DW-1:0]   mem_rdata_i = '0;
    logic            desc_valid_o, none_o, irq_o, busy_o;
    logic [2*DW-1:0] buf_ptr_o;
    logic [DW-1:0]   buf_len_o, irq_mask_o;

    int checks = 0, failures = 0;
    logic [DW-1:0] mem [0:255];

    int cyc = 0, link_wr_cnt = 0, link_wr_cyc = 0, irq_cnt = 0, irq_cyc = 0;
    int wr_cnt = 0, req_cnt = 0, none_cnt = 0;
    logic [DW-1:0] irq_mask_seen = '0;

    always #2 clk = ~clk;

    desc_chain_mgr #(.AW(AW), .DW(DW), .CB_BASE(CB)) u_dut (.*);

    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
            else          mem_rdata_i     <= mem[mem_addr_o];
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mem_req_o) req_cnt <= req_cnt + 1;
        if (mem_req_o && mem_we_o) wr_cnt <= wr_cnt + 1;
        if (mem_req_o && mem_we_o && mem_addr_o == CB + 8'd1) begin
            link_wr_cnt <= link_wr_cnt + 1;
            link_wr_cyc <= cyc;
        end
        if (irq_o) begin
            irq_cnt <= irq_cnt + 1;
            irq_cyc <= cyc;
            irq_mask_seen <= irq_mask_o;
        end
        if (none_o) none_cnt <= none_cnt + 1;
        if (cyc > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        @(negedge clk);
        link_wr_cnt = 0; irq_cnt = 0; wr_cnt = 0; req_cnt = 0; none_cnt = 0;
    endtask

    function automatic logic [AW-1:0] daddr(input int k);
        return AW'(8'h10 + k * 16);
    endfunction

    initial begin
        logic [DW-1:0] miss_exp;
        for (int a = 0; a < 256; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy_o && !mem_req_o && !desc_valid_o && !irq_o && !none_o, "R1",
              {27'd0, busy_o, mem_req_o, desc_valid_o, irq_o, none_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int rx = 0; rx < 2; rx++) begin
            for (int n = 0; n < 5; n++) begin
                logic [DW-1:0] mask;
                mask = DW'(16'h0100 * (rx + 1) + n);
                for (int k = 0; k < 5; k++) begin
                    mem[daddr(k) + 0] = (k + 1 < n) ? DW'(daddr(k + 1)) : '0;
                    mem[daddr(k) + 3] = 16'h5555;
                    mem[daddr(k) + 4] = 16'hAAAA;
                    mem[daddr(k) + 5] = DW'(16'h0100 + rx * 16 + k);
                    mem[daddr(k) + 6] = DW'(16'h1000 + k * 4 + rx);
                    mem[daddr(k) + 7] = DW'(16'h00A0 + k);
                end
                mem[CB + 1] = (n > 0) ? DW'(daddr(0)) : '0;
                mem[CB + 4] = mask;
                mem[CB + 5] = DW'(16'hFFFF - n);
                miss_exp = DW'(16'hFFFF - n);
                rx_mode_i = rx[0];

                for (int i = 0; i <= n; i++) begin
                    logic [AW-1:0] d;
                    d = daddr(i);
                    clr_counts();
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                    check(busy_o == 1'b1, "R9 busy after start", {31'd0, busy_o}, 32'd1);
                    repeat (4) begin
                        if (!desc_valid_o && !none_o) @(negedge clk);
                    end
                    if (i < n) begin
                        check(desc_valid_o, "R2 valid within 5", {31'd0, desc_valid_o}, 32'd1);
                        check(buf_len_o == DW'(16'h0100 + rx * 16 + i), "R2 len",
                              {16'd0, buf_len_o}, 32'(16'h0100 + rx * 16 + i));
                        check(buf_ptr_o == {DW'(16'h00A0 + i), DW'(16'h1000 + i * 4 + rx)}, "R2 ptr",
                              buf_ptr_o, {DW'(16'h00A0 + i), DW'(16'h1000 + i * 4 + rx)});
                        if (i == 0 && n == 2) begin
                            // R8 start while busy must be ignored
                            start_i = 1'b1;
                            @(negedge clk);
                            start_i = 1'b0;
                            repeat (3) @(negedge clk);
                            check(desc_valid_o && buf_len_o == DW'(16'h0100 + rx * 16) && wr_cnt == 0,
                                  "R8 start ignored", {16'd0, buf_len_o}, 32'(16'h0100 + rx * 16));
                        end
                        cmpl_i = DW'(16'h4000 | (i << 4) | rx);
                        used_i = DW'(16'h0020 + i);
                        done_i = 1'b1;
                        @(negedge clk);
                        done_i = 1'b0;
                        repeat (12) begin
                            if (busy_o) @(negedge clk);
                        end
                        @(negedge clk);
                        check(!busy_o, "R9 back to idle", {31'd0, busy_o}, 32'd0);
                        check(mem[d + 3] == DW'(16'h4000 | (i << 4) | rx), "R4 completion word",
                              {16'd0, mem[d + 3]}, 32'(16'h4000 | (i << 4) | rx));
                        check(mem[d + 4] == (rx == 1 ? DW'(16'h0020 + i) : 16'hAAAA), "R5 used word",
                              {16'd0, mem[d + 4]}, (rx == 1) ? 32'(16'h0020 + i) : 32'h0000AAAA);
                        check(mem[CB + 1] == ((i + 1 < n) ? DW'(daddr(i + 1)) : '0), "R6 chained pointer",
                              {16'd0, mem[CB + 1]}, (i + 1 < n) ? 32'(daddr(i + 1)) : 32'd0);
                        check(link_wr_cnt == 1, "R6 single pointer write", link_wr_cnt, 1);
                        check(irq_cnt == 1, "R7 one irq", irq_cnt, 1);
                        check(irq_mask_seen == mask, "R7 irq mask", {16'd0, irq_mask_seen}, {16'd0, mask});
                        check(irq_cyc - link_wr_cyc == 2, "R7 irq timing", irq_cyc - link_wr_cyc, 2);
                    end else begin
                        check(!desc_valid_o && none_o, "R3 none pulse", {30'd0, desc_valid_o, none_o}, 32'd1);
                        repeat (3) @(negedge clk);
                        if (rx == 1) miss_exp = miss_exp + 1'b1;
                        check(mem[CB + 5] == miss_exp, "R3 missed counter",
                              {16'd0, mem[CB + 5]}, {16'd0, miss_exp});
                        check(irq_cnt == 0 && none_cnt == 1 && !busy_o, "R3 no irq, one none",
                              irq_cnt * 16 + none_cnt, 1);
                    end
                end
            end
        end

        // R8 done while idle ignored; R10 no memory access while idle
        clr_counts();
        done_i = 1'b1;
        cmpl_i = 16'hDEAD;
        @(negedge clk);
        done_i = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy_o && irq_cnt == 0 && wr_cnt == 0, "R8 done ignored", irq_cnt + wr_cnt, 0);
        check(req_cnt == 0, "R10 idle quiet", req_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule